// File: doc/BRIEF.md
# Utilization-Driven Performance-State Governor

This block watches a group of logical processors and picks a performance state for each one from how busy it was. For every processor it counts the clock cycles in which that processor is not halted. Kernel and user activity are not told apart: any cycle with the halted flag low counts as busy. A shared counter runs alongside and counts every clock cycle of the same window, which is the number of cycles the processor would have had at full speed. When a window closes, each busy count is compared with the total against a ladder of boundaries taken from two programmable thresholds. The result is a state index per processor, where index 0 is the maximum-performance state and index NUM_PS-1 is the minimum-performance state.

The per-processor requests are then merged into one state for the package. The merge takes the highest performance that any processor asks for, so no processor in the shared domain runs slower than it requested. Windows are counted in ticks of an external timebase. A select input picks a slow window of SLOW_TICKS ticks or a fast window that is 1/FAST_RATIO as long. The block is driven by a three-state controller: ST_ARM runs for one cycle after reset, ST_ACCUM counts through the body of a window, and ST_EVAL publishes the result and also serves as the first counted cycle of the next window. The transitions are ST_ARM to ST_ACCUM unconditionally, ST_ACCUM to ST_EVAL on the closing tick, ST_ACCUM to itself otherwise, and ST_EVAL to ST_ACCUM unconditionally.

Top module: `pstate_governor`

## Requirements
- R1: While reset is asserted, and after it, until the first window has been evaluated, every processor request and the package state are 0 (maximum performance).
- R2: A processor's busy count grows by one on each cycle of the window in which its halted bit is 0. The total count grows on every cycle from the window's first cycle up to and including its closing cycle. Both counters saturate at 2^CNT_W-1.
- R3: With span = thr_hi - thr_lo (or 0 if thr_lo >= thr_hi) and D = max(NUM_PS-2,1), the boundaries are b_k = thr_hi - (span*k)/D for k = 0..NUM_PS-2, using integer division. The request index equals the number of boundaries for which busy*2^FRAC_W < b_k*total. With NUM_PS = 2 only b_0 = thr_hi exists.
- R4: Each processor's request depends only on its own halted bit. Processors with different loads receive different requests in the same window.
- R5: The package state equals the smallest index among all processor requests and changes on the same edge as the requests.
- R6: A window is SLOW_TICKS ticks long when slow and SLOW_TICKS/FAST_RATIO ticks long (at least 1) when fast. A tick in the window's first cycle counts. The window closes on the first later cycle whose tick brings the count to the length.
- R7: Requests and the package state update only on the clock edge that ends the first cycle after a window closes. At every other edge they stay unchanged.
- R8: win_fast is sampled only in a window's first cycle. A change later in the window does not alter that window's length.
- R9: When thr_lo is greater than or equal to thr_hi, every boundary equals thr_hi, so each request is either 0 or NUM_PS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halted | input | NUM_LP | Per-processor halted flag, 1 = idle this cycle |
| tick | input | 1 | Timebase pulse used to measure window length |
| win_fast | input | 1 | Window select, 1 = fast, 0 = slow |
| thr_hi | input | FRAC_W | Busy fraction (in 1/2^FRAC_W units) at or above which index 0 is chosen |
| thr_lo | input | FRAC_W | Busy fraction below which index NUM_PS-1 is chosen |
| lp_req | output | NUM_LP*IDX_W | Per-processor requested state index; processor i sits in bits [i*IDX_W +: IDX_W] |
| pkg_state | output | IDX_W | Resolved package state index |

## Verification
A busy or total counter that drifts by a single cycle first shows at the ports as a wrong lp_req field on the edge that ends the first cycle of the next window, and only when the count lies near a boundary. For that reason the sweeps walk the busy counts one step at a time through every boundary. A fault in the tick counter or the length latch shifts the closing cycle, so a stale value appears when the bench samples the results, or a value changes in the middle of a window. Both effects show up within one fast window. A fault in the package resolver shows on the same edge as the requests whenever processors in that window disagree.

// File: rtl/pgov_pkg.sv
package pgov_pkg;

    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_ACCUM = 2'd1,
        ST_EVAL  = 2'd2
    } gov_state_t;

endpackage

// File: rtl/pgov_cycle_counter.sv
module pgov_cycle_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            // first cycle of a window counts itself
            cnt <= CNT_W'(inc);
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pgov_window_timer.sv
module pgov_window_timer #(
    parameter int SLOW_TICKS = 1200,
    parameter int FAST_TICKS = 10,
    parameter int TICK_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              counting,
    input  logic              tick,
    input  logic              win_fast,
    output logic              boundary,
    output logic [TICK_W-1:0] tick_cnt,
    output logic              len_fast
);

    localparam logic [TICK_W:0] LEN_SLOW = (TICK_W+1)'(SLOW_TICKS);
    localparam logic [TICK_W:0] LEN_FAST = (TICK_W+1)'(FAST_TICKS);

    logic [TICK_W:0] cur_len;
    logic [TICK_W:0] next_cnt;

    always_comb begin
        cur_len  = len_fast ? LEN_FAST : LEN_SLOW;
        next_cnt = {1'b0, tick_cnt} + 1'b1;
        boundary = counting && tick && (next_cnt >= cur_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            len_fast <= 1'b0;
        end else if (restart) begin
            tick_cnt <= TICK_W'(tick);
            len_fast <= win_fast;
        end else if (tick) begin
            tick_cnt <= next_cnt[TICK_W-1:0];
        end
    end

endmodule

// File: rtl/pgov_level_map.sv
module pgov_level_map #(
    parameter int NUM_PS = 4,
    parameter int FRAC_W = 8,
    parameter int CNT_W  = 24,
    parameter int IDX_W  = 2
) (
    input  logic [CNT_W-1:0]               busy,
    input  logic [CNT_W-1:0]               total,
    input  logic [(NUM_PS-1)*FRAC_W-1:0]   bnd,
    output logic [IDX_W-1:0]               idx
);

    localparam int PW = CNT_W + FRAC_W;

    logic [PW-1:0] scaled_busy;
    logic [PW-1:0] limit [NUM_PS-1];
    logic [NUM_PS-2:0] below;

    assign scaled_busy = {busy, {FRAC_W{1'b0}}};

    generate
        for (genvar k = 0; k < NUM_PS-1; k++) begin : g_step
            assign limit[k] = PW'(bnd[k*FRAC_W +: FRAC_W]) * PW'(total);
            assign below[k] = scaled_busy < limit[k];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int k = 0; k < NUM_PS-1; k++) begin
            idx = idx + IDX_W'(below[k]);
        end
    end

endmodule

// File: rtl/pgov_resolver.sv
module pgov_resolver #(
    parameter int NUM_LP = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_LP*IDX_W-1:0] reqs,
    output logic [IDX_W-1:0]        fastest
);

    always_comb begin
        fastest = reqs[IDX_W-1:0];
        for (int i = 1; i < NUM_LP; i++) begin
            if (reqs[i*IDX_W +: IDX_W] < fastest) begin
                fastest = reqs[i*IDX_W +: IDX_W];
            end
        end
    end

endmodule

// File: rtl/pstate_governor.sv
module pstate_governor #(
    parameter int NUM_LP     = 4,
    parameter int NUM_PS     = 4,
    parameter int CNT_W      = 24,
    parameter int FRAC_W     = 8,
    parameter int SLOW_TICKS = 1200,
    parameter int FAST_RATIO = 120,
    parameter int IDX_W      = $clog2(NUM_PS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LP-1:0]        halted,
    input  logic                     tick,
    input  logic                     win_fast,
    input  logic [FRAC_W-1:0]        thr_hi,
    input  logic [FRAC_W-1:0]        thr_lo,
    output logic [NUM_LP*IDX_W-1:0]  lp_req,
    output logic [IDX_W-1:0]         pkg_state
);

    import pgov_pkg::*;

    localparam int FAST_RAW   = SLOW_TICKS / FAST_RATIO;
    localparam int FAST_TICKS = (FAST_RAW > 0) ? FAST_RAW : 1;
    localparam int TICK_W     = $clog2(SLOW_TICKS + 2);
    localparam int LADDER_DIV = (NUM_PS > 2) ? NUM_PS - 2 : 1;
    localparam int SPAN_W     = FRAC_W + IDX_W + 1;

    gov_state_t state_q, state_d;

    logic restart;
    logic counting;
    logic publish;
    logic boundary;
    logic len_fast;
    logic [TICK_W-1:0] tick_cnt;

    logic [CNT_W-1:0]              total_q;
    logic [NUM_LP*CNT_W-1:0]       busy_flat;
    logic [FRAC_W-1:0]             span;
    logic [(NUM_PS-1)*FRAC_W-1:0]  bnd_flat;
    logic [NUM_LP*IDX_W-1:0]       req_nxt;
    logic [NUM_LP*IDX_W-1:0]       req_q;
    logic [IDX_W-1:0]              pkg_nxt;
    logic [IDX_W-1:0]              pkg_q;

    // ---------------- controller: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- controller: next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM:   state_d = ST_ACCUM;
            ST_ACCUM: state_d = boundary ? ST_EVAL : ST_ACCUM;
            ST_EVAL:  state_d = ST_ACCUM;
            default:  state_d = ST_ARM;
        endcase
    end

    // ---------------- controller: outputs ----------------
    always_comb begin
        restart  = 1'b0;
        counting = 1'b0;
        publish  = 1'b0;
        unique case (state_q)
            ST_ARM: begin
                restart = 1'b1;
            end
            ST_ACCUM: begin
                counting = 1'b1;
            end
            ST_EVAL: begin
                restart = 1'b1;
                publish = 1'b1;
            end
            default: begin
                restart = 1'b1;
            end
        endcase
    end

    // ---------------- window timing ----------------
    pgov_window_timer #(
        .SLOW_TICKS (SLOW_TICKS),
        .FAST_TICKS (FAST_TICKS),
        .TICK_W     (TICK_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .counting (counting),
        .tick     (tick),
        .win_fast (win_fast),
        .boundary (boundary),
        .tick_cnt (tick_cnt),
        .len_fast (len_fast)
    );

    // ---------------- cycle counters ----------------
    pgov_cycle_counter #(
        .CNT_W (CNT_W)
    ) u_total (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .inc     (1'b1),
        .cnt     (total_q)
    );

    generate
        for (genvar i = 0; i < NUM_LP; i++) begin : g_lp
            pgov_cycle_counter #(
                .CNT_W (CNT_W)
            ) u_busy (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (restart),
                .inc     (~halted[i]),
                .cnt     (busy_flat[i*CNT_W +: CNT_W])
            );

            pgov_level_map #(
                .NUM_PS (NUM_PS),
                .FRAC_W (FRAC_W),
                .CNT_W  (CNT_W),
                .IDX_W  (IDX_W)
            ) u_map (
                .busy  (busy_flat[i*CNT_W +: CNT_W]),
                .total (total_q),
                .bnd   (bnd_flat),
                .idx   (req_nxt[i*IDX_W +: IDX_W])
            );
        end
    endgenerate

    // ---------------- threshold ladder ----------------
    assign span = (thr_hi > thr_lo) ? (thr_hi - thr_lo) : '0;

    generate
        for (genvar k = 0; k < NUM_PS-1; k++) begin : g_rung
            logic [SPAN_W-1:0] drop;
            assign drop = (SPAN_W'(span) * SPAN_W'(k)) / SPAN_W'(LADDER_DIV);
            assign bnd_flat[k*FRAC_W +: FRAC_W] = thr_hi - drop[FRAC_W-1:0];
        end
    endgenerate

    // ---------------- package resolution ----------------
    pgov_resolver #(
        .NUM_LP (NUM_LP),
        .IDX_W  (IDX_W)
    ) u_resolve (
        .reqs    (req_nxt),
        .fastest (pkg_nxt)
    );

    // ---------------- published results ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            pkg_q <= '0;
        end else if (publish) begin
            req_q <= req_nxt;
            pkg_q <= pkg_nxt;
        end
    end

    assign lp_req    = req_q;
    assign pkg_state = pkg_q;

endmodule

// File: rtl/pgov_checker.sv
module pgov_checker #(
    parameter int NUM_LP     = 4,
    parameter int CNT_W      = 24,
    parameter int SLOW_TICKS = 1200,
    parameter int TICK_W     = 11,
    parameter int IDX_W      = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              state_q,
    input logic [NUM_LP*IDX_W-1:0] lp_req,
    input logic [IDX_W-1:0]        pkg_state,
    input logic [NUM_LP*CNT_W-1:0] busy_flat,
    input logic [CNT_W-1:0]        total_q,
    input logic [TICK_W-1:0]       tick_cnt,
    input logic                    len_fast
);

    import pgov_pkg::*;

    logic pkg_matches;

    always_comb begin
        pkg_matches = 1'b0;
        for (int i = 0; i < NUM_LP; i++) begin
            if (lp_req[i*IDX_W +: IDX_W] == pkg_state) begin
                pkg_matches = 1'b1;
            end
        end
    end

    generate
        for (genvar i = 0; i < NUM_LP; i++) begin : g_chk
            // R5
            pkg_not_slower_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pkg_state <= lp_req[i*IDX_W +: IDX_W]);
            // R2
            busy_within_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
                busy_flat[i*CNT_W +: CNT_W] <= total_q);
        end
    endgenerate

    // R5
    pkg_is_a_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkg_matches);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EVAL) |=> $stable(lp_req));

    // R7
    pkg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EVAL) |=> $stable(pkg_state));

    // R8
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCUM) |=> $stable(len_fast));

    // R6
    tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, tick_cnt} <= (TICK_W+1)'(SLOW_TICKS));

endmodule

bind pstate_governor pgov_checker #(
    .NUM_LP     (NUM_LP),
    .CNT_W      (CNT_W),
    .SLOW_TICKS (SLOW_TICKS),
    .TICK_W     (TICK_W),
    .IDX_W      (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .lp_req    (lp_req),
    .pkg_state (pkg_state),
    .busy_flat (busy_flat),
    .total_q   (total_q),
    .tick_cnt  (tick_cnt),
    .len_fast  (len_fast)
);

// File: tb/pstate_governor_tb.sv
module pstate_governor_tb;

    localparam int NLP  = 4;
    localparam int NPS  = 4;
    localparam int IW   = 2;
    localparam int FW   = 8;
    localparam int SLOW = 1200;
    localparam int FAST = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NLP-1:0]  halted = '1;
    logic            tick = 1'b0;
    logic            win_fast = 1'b0;
    logic [FW-1:0]   thr_hi = 8'd192;
    logic [FW-1:0]   thr_lo = 8'd64;
    logic [NLP*IW-1:0] lp_req;
    logic [IW-1:0]   pkg_state;

    always #10 clk = ~clk;

    pstate_governor u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .halted    (halted),
        .tick      (tick),
        .win_fast  (win_fast),
        .thr_hi    (thr_hi),
        .thr_lo    (thr_lo),
        .lp_req    (lp_req),
        .pkg_state (pkg_state)
    );

    int n_chk = 0;
    int n_bad = 0;
    int have_prev = 0;
    int pat_mode = 0;
    int nxt_hi = 192;
    int nxt_lo = 64;
    int exp_req [NLP];
    int hold_req [NLP];
    int hold_pkg = 0;
    int busy_goal [NLP];

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int got(input int i);
        return int'(lp_req[i*IW +: IW]);
    endfunction

    function automatic int ref_idx(input longint b, input longint t, input int hi, input int lo);
        int span = (hi > lo) ? hi - lo : 0;
        int dv = (NPS > 2) ? NPS - 2 : 1;
        int n = 0;
        for (int k = 0; k < NPS-1; k++) begin
            longint bk = longint'(hi - (span * k) / dv);
            if (b * 256 < bk * t) n++;
        end
        return n;
    endfunction

    function automatic int exp_pkg();
        int m = exp_req[0];
        for (int i = 1; i < NLP; i++) if (exp_req[i] < m) m = exp_req[i];
        return m;
    endfunction

    // one window: length fixed by the select value at its first cycle (R6, R8)
    task automatic run_window(input bit fast, input int period, input int flip_at);
        int len = fast ? FAST : SLOW;
        int c = 0;
        int ticks = 0;
        bit done = 0;
        int bcnt [NLP];
        for (int i = 0; i < NLP; i++) bcnt[i] = 0;
        while (!done) begin
            @(negedge clk);
            if (c == 1) begin
                if (have_prev != 0) begin
                    for (int i = 0; i < NLP; i++) check($sformatf("R3 R4 lp%0d", i), got(i), exp_req[i]);
                    check("R5 pkg", int'(pkg_state), exp_pkg());
                end else begin
                    for (int i = 0; i < NLP; i++) check($sformatf("R1 lp%0d", i), got(i), 0);
                    check("R1 pkg", int'(pkg_state), 0);
                end
                for (int i = 0; i < NLP; i++) hold_req[i] = got(i);
                hold_pkg = int'(pkg_state);
            end
            if (c == 2) begin
                thr_hi = FW'(nxt_hi);
                thr_lo = FW'(nxt_lo);
            end
            win_fast = (flip_at > 0 && c >= flip_at) ? ~fast : fast;
            tick = ((c % period) == 0);
            for (int i = 0; i < NLP; i++) begin
                bit act;
                if (pat_mode == 0) act = (c < busy_goal[i]);
                else act = (((c * (i + 1)) + i) % 5) < busy_goal[i];
                halted[i] = ~act;
                if (act) bcnt[i]++;
            end
            if (tick) ticks++;
            if (c >= 1 && tick && ticks >= len) begin
                done = 1;
                if (c >= 2) begin
                    for (int i = 0; i < NLP; i++) check($sformatf("R7 hold lp%0d", i), got(i), hold_req[i]);
                    check("R7 hold pkg", int'(pkg_state), hold_pkg);
                end
            end
            @(posedge clk);
            c++;
        end
        // R2: busy fraction over every cycle of the window
        for (int i = 0; i < NLP; i++)
            exp_req[i] = ref_idx(longint'(bcnt[i]), longint'(c), int'(thr_hi), int'(thr_lo));
        have_prev = 1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NLP; i++) check($sformatf("R1 in reset lp%0d", i), got(i), 0);
        check("R1 in reset pkg", int'(pkg_state), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // sweep busy counts through all boundaries, spread thresholds (R2 R3 R4 R5)
        pat_mode = 0;
        for (int b = 0; b <= FAST; b++) begin
            for (int i = 0; i < NLP; i++) busy_goal[i] = (b + 3 * i) % (FAST + 1);
            run_window(1'b1, 1, 0);
        end

        // equal thresholds: two-level decisions (R9)
        nxt_hi = 128; nxt_lo = 128;
        for (int b = 0; b <= FAST; b++) begin
            for (int i = 0; i < NLP; i++) busy_goal[i] = (b + 5 * i) % (FAST + 1);
            run_window(1'b1, 1, 0);
        end

        // low threshold above high threshold (R9)
        nxt_hi = 100; nxt_lo = 200;
        for (int b = 0; b <= FAST; b += 2) begin
            for (int i = 0; i < NLP; i++) busy_goal[i] = (b + 2 * i) % (FAST + 1);
            run_window(1'b1, 1, 0);
        end

        // interleaved halts, ticks every other cycle (R2 R6)
        nxt_hi = 230; nxt_lo = 20;
        pat_mode = 1;
        for (int b = 0; b <= 5; b++) begin
            for (int i = 0; i < NLP; i++) busy_goal[i] = (b + i) % 6;
            run_window(1'b1, 2, 0);
        end

        // select flips mid-window: current window stays fast (R8), then a slow window (R6)
        nxt_hi = 192; nxt_lo = 64;
        pat_mode = 0;
        for (int i = 0; i < NLP; i++) busy_goal[i] = 2 * i + 1;
        run_window(1'b1, 1, 3);
        for (int i = 0; i < NLP; i++) busy_goal[i] = 300 * i + 300;
        run_window(1'b0, 1, 0);

        // one processor loaded, the rest idle (R4 R5)
        busy_goal[0] = FAST; busy_goal[1] = 0; busy_goal[2] = 0; busy_goal[3] = 0;
        run_window(1'b1, 1, 0);
        busy_goal[0] = 0; busy_goal[1] = 0; busy_goal[2] = 7; busy_goal[3] = 0;
        run_window(1'b1, 3, 0);
        run_window(1'b1, 1, 0);

        // reset in the middle of operation (R1)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NLP; i++) check($sformatf("R1 re-reset lp%0d", i), got(i), 0);
        check("R1 re-reset pkg", int'(pkg_state), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule